// File: doc/BRIEF.md
# Linear-Interpolating Waveform Table Player

This block plays a waveform table stored on chip at a programmable virtual sample rate. It turns that stream into output samples at the fixed core clock rate. Table entries are visited strictly in order, one entry per tick of the virtual sample clock, and reading wraps from the last entry back to entry 0 without a break. A 32-bit phase accumulator sets how many output samples fall between two entries. The top fractional bits of that accumulator weight a linear interpolation between the current entry and the one after it.

Software loads the table through a write port and programs the table length and the rate step. It then holds `run_i` high to play. One signed sample leaves per clock, marked by `valid_o`. The step is a fraction of the output rate, so 0x4000_0000 means one table entry every four output samples. Larger steps are clamped to that value, which keeps the virtual rate at or below a quarter of the output rate.

Top module: `lerp_player`

## Requirements
- R1: While reset is held and after it is released, `valid_o` is 0 and `sample_o` is 0. Whenever `valid_o` is 0, `sample_o` is 0.
- R2: A clock with `tbl_we_i` high stores `tbl_data_i` at table address `tbl_addr_i`. Entries 0 to length-1 are the ones played.
- R3: A value written through `step_we_i` that is above 0x4000_0000 is stored as 0x4000_0000. Other values are stored unchanged.
- R4: A length written through `len_we_i` is clamped to the range 2 to 4096.
- R5: Each clock while running, the step is added modulo 2^32 to the phase accumulator. A carry out advances the read index by exactly one entry, so no entry is skipped.
- R6: When the index advances from entry length-1, it goes to entry 0.
- R7: For output k after start, let acc = k*step mod 2^32 and idx = floor(k*step / 2^32) mod length. The output is a + floor((b-a)*w / 4096), where a = entry idx, b = entry (idx+1) mod length, and w = acc[31:20].
- R8: With step 0x4000_0000, output 4i equals entry i, and the output sequence repeats every 4*length samples.
- R9: With a non-integer step, such as 297.5/1200 of full scale, the fractional residue carries across entries and periods. Every output follows R7 with no reset of the phase at the wrap.
- R10: With step 0, the output holds its value. This includes a step written as 0 while playback runs.
- R11: A rising `run_i` clears the accumulator and index, so the first valid sample equals entry 0.
- R12: A clock with `run_i` low drives `valid_o` to 0 and `sample_o` to 0 at that edge.
- R13: `valid_o` first rises on the fourth rising edge that samples `run_i` high. The three edges before it leave `valid_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Output-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_addr_i | input | 12 | Table write address |
| tbl_data_i | input | 16 | Table write data, signed |
| len_we_i | input | 1 | Length write strobe |
| len_i | input | 13 | Table length in entries |
| step_we_i | input | 1 | Step write strobe |
| step_i | input | 32 | Phase step per output sample |
| run_i | input | 1 | Play while high; a rising edge restarts |
| sample_o | output | 16 | Interpolated output sample, signed |
| valid_o | output | 1 | Output sample valid |

## Verification
Three events can land on the same clock edge: the accumulator carry that advances the index, the index wrap to entry 0, and the interpolation reading its second operand across that wrap. Short tables played at the maximum step drive the carry and the wrap together every few samples. A fractional step moves the wrap to a different weight on each pass. Each output is compared against a reference computed from R7 using the bench's own copy of the table. A second overlap is a step or length write landing on a running pipeline. It is judged by writing the step to zero during playback and checking that the output then freezes.

// File: rtl/lerp_pkg.sv
package lerp_pkg;
  localparam int unsigned SMP_W = 16;
  localparam int unsigned PH_W  = 32;
  localparam int unsigned WT_W  = 12;
  localparam logic [PH_W-1:0] STEP_CAP = 32'h4000_0000;
  typedef logic signed [SMP_W-1:0] smp_t;
endpackage

// File: rtl/lerp_cfg.sv
module lerp_cfg
  import lerp_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_we_i,
  input  logic [PH_W-1:0]   step_i,
  input  logic              len_we_i,
  input  logic [ADDR_W:0]   len_i,
  output logic [PH_W-1:0]   step_o,
  output logic [ADDR_W:0]   len_o
);
  localparam logic [ADDR_W:0] LEN_MAX = (ADDR_W+1)'(1) << ADDR_W;
  localparam logic [ADDR_W:0] LEN_MIN = (ADDR_W+1)'(2);

  logic [PH_W-1:0] step_cl;
  logic [ADDR_W:0] len_cl;

  always_comb begin
    step_cl = (step_i > STEP_CAP) ? STEP_CAP : step_i;
    if (len_i < LEN_MIN)      len_cl = LEN_MIN;
    else if (len_i > LEN_MAX) len_cl = LEN_MAX;
    else                      len_cl = len_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_o <= '0;
      len_o  <= LEN_MAX;
    end else begin
      if (step_we_i) step_o <= step_cl;
      if (len_we_i)  len_o  <= len_cl;
    end
  end
endmodule

// File: rtl/lerp_phase.sv
module lerp_phase
  import lerp_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [PH_W-1:0]   step_i,
  input  logic [ADDR_W:0]   len_i,
  output logic [ADDR_W-1:0] idx_o,
  output logic [ADDR_W-1:0] nxt_o,
  output logic [WT_W-1:0]   wt_o,
  output logic              vld_o
);
  logic              run_q;
  logic [PH_W-1:0]   acc_q;
  logic [ADDR_W-1:0] idx_q;
  logic [PH_W:0]     sum;
  logic [ADDR_W-1:0] last;
  logic              at_last;

  assign sum     = {1'b0, acc_q} + {1'b0, step_i};
  assign last    = ADDR_W'(len_i - 1'b1);
  // length may shrink under a running index: treat anything past the end as last
  assign at_last = idx_q >= last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      acc_q <= '0;
      idx_q <= '0;
      vld_o <= 1'b0;
    end else begin
      run_q <= run_i;
      if (!run_i) begin
        acc_q <= '0;
        idx_q <= '0;
        vld_o <= 1'b0;
      end else if (!run_q) begin
        acc_q <= '0;
        idx_q <= '0;
        vld_o <= 1'b1;
      end else begin
        acc_q <= sum[PH_W-1:0];
        if (sum[PH_W]) idx_q <= at_last ? '0 : idx_q + 1'b1;
      end
    end
  end

  assign idx_o = idx_q;
  assign nxt_o = at_last ? '0 : idx_q + 1'b1;
  assign wt_o  = acc_q[PH_W-1 -: WT_W];
endmodule

// File: rtl/lerp_table.sv
module lerp_table
  import lerp_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned N_RD   = 2
) (
  input  logic                       clk_i,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          wa_i,
  input  logic [SMP_W-1:0]           wd_i,
  input  logic [N_RD-1:0][ADDR_W-1:0] ra_i,
  output logic [N_RD-1:0][SMP_W-1:0]  rd_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  // one bank per read port, all written together
  for (genvar g = 0; g < N_RD; g++) begin : g_bank
    logic [SMP_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i) mem[wa_i] <= wd_i;
      rd_o[g] <= mem[ra_i[g]];
    end
  end
endmodule

// File: rtl/lerp_datapath.sv
module lerp_datapath
  import lerp_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            vld_i,
  input  logic [WT_W-1:0] wt_i,
  input  smp_t            a_i,
  input  smp_t            b_i,
  output smp_t            sample_o,
  output logic            valid_o
);
  localparam int unsigned DIF_W = SMP_W + 1;
  localparam int unsigned PRD_W = DIF_W + WT_W + 1;
  localparam logic signed [PRD_W-1:0] POS_LIM = PRD_W'((1 << (SMP_W-1)) - 1);
  localparam logic signed [PRD_W-1:0] NEG_LIM = -PRD_W'(1 << (SMP_W-1));

  logic                    vld_s1, vld_s2;
  logic [WT_W-1:0]         wt_s1;
  smp_t                    a_s2;
  logic signed [PRD_W-1:0] prd_s2;
  logic signed [DIF_W-1:0] dif;
  logic signed [PRD_W-1:0] y_full;
  smp_t                    y_sat;

  assign dif = {b_i[SMP_W-1], b_i} - {a_i[SMP_W-1], a_i};

  always_comb begin
    y_full = PRD_W'(a_s2) + (prd_s2 >>> WT_W);
    if (y_full > POS_LIM)      y_sat = smp_t'(POS_LIM);
    else if (y_full < NEG_LIM) y_sat = smp_t'(NEG_LIM);
    else                       y_sat = smp_t'(y_full);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_s1   <= 1'b0;
      vld_s2   <= 1'b0;
      wt_s1    <= '0;
      a_s2     <= '0;
      prd_s2   <= '0;
      sample_o <= '0;
      valid_o  <= 1'b0;
    end else if (!run_i) begin
      vld_s1   <= 1'b0;
      vld_s2   <= 1'b0;
      sample_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      vld_s1   <= vld_i;
      wt_s1    <= wt_i;
      vld_s2   <= vld_s1;
      a_s2     <= a_i;
      prd_s2   <= PRD_W'(dif) * $signed({1'b0, wt_s1});
      valid_o  <= vld_s2;
      sample_o <= vld_s2 ? y_sat : '0;
    end
  end
endmodule

// File: rtl/lerp_player.sv
module lerp_player
  import lerp_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tbl_we_i,
  input  logic [ADDR_W-1:0] tbl_addr_i,
  input  logic [SMP_W-1:0]  tbl_data_i,
  input  logic              len_we_i,
  input  logic [ADDR_W:0]   len_i,
  input  logic              step_we_i,
  input  logic [PH_W-1:0]   step_i,
  input  logic              run_i,
  output logic [SMP_W-1:0]  sample_o,
  output logic              valid_o
);
  logic [PH_W-1:0]          step_q;
  logic [ADDR_W:0]          len_q;
  logic [ADDR_W-1:0]        idx_q, nxt_idx;
  logic [WT_W-1:0]          wt_s0;
  logic                     vld_s0;
  logic [1:0][ADDR_W-1:0]   rd_addr;
  logic [1:0][SMP_W-1:0]    rd_data;
  smp_t                     smp_out;

  lerp_cfg #(.ADDR_W(ADDR_W)) u_cfg (
    .clk_i, .rst_ni,
    .step_we_i, .step_i, .len_we_i, .len_i,
    .step_o (step_q),
    .len_o  (len_q)
  );

  lerp_phase #(.ADDR_W(ADDR_W)) u_phase (
    .clk_i, .rst_ni, .run_i,
    .step_i (step_q),
    .len_i  (len_q),
    .idx_o  (idx_q),
    .nxt_o  (nxt_idx),
    .wt_o   (wt_s0),
    .vld_o  (vld_s0)
  );

  assign rd_addr[0] = idx_q;
  assign rd_addr[1] = nxt_idx;

  lerp_table #(.ADDR_W(ADDR_W), .N_RD(2)) u_tbl (
    .clk_i,
    .we_i (tbl_we_i),
    .wa_i (tbl_addr_i),
    .wd_i (tbl_data_i),
    .ra_i (rd_addr),
    .rd_o (rd_data)
  );

  lerp_datapath u_dp (
    .clk_i, .rst_ni, .run_i,
    .vld_i    (vld_s0),
    .wt_i     (wt_s0),
    .a_i      (smp_t'(rd_data[0])),
    .b_i      (smp_t'(rd_data[1])),
    .sample_o (smp_out),
    .valid_o  (valid_o)
  );

  assign sample_o = smp_out;
endmodule

// File: rtl/lerp_player_chk.sv
module lerp_player_chk
  import lerp_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_i,
  input logic              valid_o,
  input logic [SMP_W-1:0]  sample_o,
  input logic [PH_W-1:0]   step_q,
  input logic [ADDR_W:0]   len_q,
  input logic [ADDR_W-1:0] idx_q
);
  localparam logic [ADDR_W:0] LEN_MAX = (ADDR_W+1)'(1) << ADDR_W;

  // R1
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> sample_o == '0);

  // R12
  stop_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!valid_o && sample_o == '0));

  // R13
  start_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> ($past(run_i, 1) && $past(run_i, 2) && $past(run_i, 3)));

  // R3
  step_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q <= STEP_CAP);

  // R4
  len_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_q >= (ADDR_W+1)'(2)) && (len_q <= LEN_MAX));

  // R5
  idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_q != $past(idx_q)) |-> (idx_q == $past(idx_q) + 1'b1 || idx_q == '0));

  // R6
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_i, 2) && $past(run_i) && idx_q == '0 && $past(idx_q) != '0)
      |-> ({1'b0, $past(idx_q)} >= $past(len_q) - 1'b1));
endmodule

bind lerp_player lerp_player_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .run_i    (run_i),
  .valid_o  (valid_o),
  .sample_o (sample_o),
  .step_q   (step_q),
  .len_q    (len_q),
  .idx_q    (idx_q)
);

// File: tb/lerp_player_tb_top.sv
module lerp_player_tb_top;
  localparam int ADDR_W = 12;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam logic [31:0] CAP = 32'h4000_0000;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              tbl_we_i = 1'b0;
  logic [ADDR_W-1:0] tbl_addr_i = '0;
  logic [15:0]       tbl_data_i = '0;
  logic              len_we_i = 1'b0;
  logic [ADDR_W:0]   len_i = '0;
  logic              step_we_i = 1'b0;
  logic [31:0]       step_i = '0;
  logic              run_i = 1'b0;
  logic [15:0]       sample_o;
  logic              valid_o;

  always #2 clk = ~clk;

  lerp_player #(.ADDR_W(ADDR_W)) dut_i (
    .clk_i(clk), .rst_ni, .tbl_we_i, .tbl_addr_i, .tbl_data_i,
    .len_we_i, .len_i, .step_we_i, .step_i, .run_i, .sample_o, .valid_o
  );

  int n_run = 0;
  int n_fail = 0;
  logic signed [15:0] tbl_m [DEPTH];
  logic [31:0] step_m = '0;
  int          len_m = DEPTH;
  longint      got [1024];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exp_smp(input longint k);
    longint unsigned tot, acc;
    longint idx, w, a, b;
    tot = longint'(k) * longint'({32'd0, step_m});
    acc = tot & 64'hFFFF_FFFF;
    idx = longint'(tot >> 32) % len_m;
    w   = longint'(acc >> 20);
    a   = longint'(tbl_m[idx]);
    b   = longint'(tbl_m[(idx + 1) % len_m]);
    return a + (((b - a) * w) >>> 12);
  endfunction

  task automatic put_entry(input int adr, input logic signed [15:0] d);
    @(negedge clk);
    tbl_we_i = 1'b1; tbl_addr_i = ADDR_W'(adr); tbl_data_i = d;
    tbl_m[adr] = d;
    @(negedge clk);
    tbl_we_i = 1'b0;
  endtask

  task automatic set_step(input logic [31:0] v);
    @(negedge clk);
    step_we_i = 1'b1; step_i = v;
    @(negedge clk);
    step_we_i = 1'b0;
    step_m = (v > CAP) ? CAP : v;
  endtask

  task automatic set_len(input int v);
    @(negedge clk);
    len_we_i = 1'b1; len_i = (ADDR_W+1)'(v);
    @(negedge clk);
    len_we_i = 1'b0;
    len_m = (v < 2) ? 2 : ((v > DEPTH) ? DEPTH : v);
  endtask

  // raise run, check latency, compare n samples against the reference
  task automatic play(input int n, input string req);
    @(negedge clk);
    run_i = 1'b1;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk(valid_o == 1'b0, "R13 valid before latency", longint'(valid_o), 0);
    end
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      got[k] = longint'($signed(sample_o));
      chk(valid_o == 1'b1, {req, " valid"}, longint'(valid_o), 1);
      chk(got[k] == exp_smp(k), req, got[k], exp_smp(k));
    end
  endtask

  task automatic stop_run();
    @(negedge clk);
    run_i = 1'b0;
    @(negedge clk);
    chk(valid_o == 1'b0, "R12 valid after stop", longint'(valid_o), 0);
    chk(sample_o == 16'd0, "R12 sample after stop", longint'($signed(sample_o)), 0);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(valid_o == 1'b0 && sample_o == 16'd0, "R1 in reset", longint'(sample_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(valid_o == 1'b0 && sample_o == 16'd0, "R1 after reset", longint'(sample_o), 0);
  endtask

  task automatic t_quarter_ramp();
    for (int i = 0; i < 16; i++) put_entry(i, 16'(i * 1000 - 8000));
    set_len(16);
    set_step(CAP);
    play(80, "R7 R5 R6 quarter ramp");
    for (int i = 0; i < 16; i++)
      chk(got[4*i] == longint'(tbl_m[i]), "R8 entry on grid", got[4*i], longint'(tbl_m[i]));
    for (int k = 0; k < 16; k++)
      chk(got[k] == got[k+64], "R8 period 4*len", got[k+64], got[k]);
    stop_run();
  endtask

  task automatic t_square_frac();
    for (int i = 0; i < 30; i++) put_entry(i, (i < 15) ? 16'sd12000 : -16'sd12000);
    set_len(30);
    set_step(32'(64'd4294967296 * 64'd2975 / 64'd12000));
    play(400, "R9 fractional step");
    stop_run();
  endtask

  task automatic t_clamps();
    set_step(32'hFFFF_FFFF);
    put_entry(0, 16'sd100);
    put_entry(1, -16'sd100);
    put_entry(2, 16'sd5000);
    set_len(1);
    play(24, "R3 R4 clamp short table");
    stop_run();
    set_len(8191);
    set_step(32'h1234_5678);
    play(40, "R4 R3 clamp long table");
    stop_run();
  endtask

  task automatic t_hold();
    put_entry(0, 16'sd777);
    set_len(8);
    set_step(32'd0);
    play(10, "R10 R2 step zero");
    chk(got[9] == 777, "R2 written entry", got[9], 777);
    stop_run();
    set_step(CAP);
    @(negedge clk);
    run_i = 1'b1;
    repeat (9) @(negedge clk);
    step_we_i = 1'b1; step_i = 32'd0;
    @(negedge clk);
    step_we_i = 1'b0;
    step_m = 32'd0;
    repeat (5) @(negedge clk);
    got[0] = longint'($signed(sample_o));
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk(valid_o && longint'($signed(sample_o)) == got[0], "R10 hold mid run",
          longint'($signed(sample_o)), got[0]);
    end
    stop_run();
  endtask

  task automatic t_restart();
    set_len(16);
    set_step(32'h2800_0000);
    play(30, "R11 first run");
    stop_run();
    play(30, "R11 restart from entry 0");
    chk(got[0] == longint'(tbl_m[0]), "R11 first sample is entry 0", got[0], longint'(tbl_m[0]));
    stop_run();
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) tbl_m[i] = '0;
    // clear the first entries so the reference matches the RAM
    t_reset();
    for (int i = 0; i < 40; i++) put_entry(i, 16'sd0);
    t_quarter_ramp();
    t_square_frac();
    t_clamps();
    t_hold();
    t_restart();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule